// File: doc/BRIEF.md
# Broadcast Constant Cache with Address Serialization

This block is a read-only cache that sits in front of a larger backing memory and serves the constant-memory loads of a group of lanes that issue together. Each lane has its own word address and an active bit. The cache has one read port, so it returns one data word per cycle. That word goes to every pending lane that asked for the same word address. When all active lanes use one address and the line is resident, the load completes in the cycle it is presented. When lanes use different addresses, the block takes one distinct address per cycle and holds the issuer with a stall signal until every active lane has been answered.

The cache is direct-mapped. On a miss it fetches the whole line through a simple request/response memory port and then retries the lookup. Lanes whose address is outside the constant space are answered with an error flag and a zero word, and nothing is fetched for them. There is no write path. Nothing keeps the cache coherent with the backing store.

Top module: `const_bcast_cache`

## Requirements
- R1: After reset `stall`, `rsp_valid` and `mem_req_valid` are low and every line is invalid, so the first access to any line fetches it.
- R2: When every active lane carries the same word address and that line is resident, the load completes in one cycle: `rsp_valid` is high, `rsp_mask` equals `req_mask` and `stall` is low in the cycle the request is presented.
- R3: In each serving cycle the address chosen is the one held by the lowest-numbered lane still pending. `rsp_mask` then holds exactly the pending lanes with that same word address.
- R4: `stall` is high in every cycle that leaves an active lane unanswered. It is low in the cycle that answers the last pending lanes. The number of serving cycles equals the number of distinct word addresses among the active lanes.
- R5: Inactive lanes never appear in `rsp_mask`. A request with an all-zero mask gives no response and no stall.
- R6: On a miss the block raises `mem_req_valid` with `mem_req_line` = word address / words-per-line. It holds both until `mem_req_ready`, then takes one `mem_rsp_valid` beat per word in ascending word order. It gives no response while the fill is in progress.
- R7: The line index is the line address modulo the number of lines. A resident line stays resident until a line with the same index replaces it, and a replaced line is fetched again on its next use.
- R8: A word address at or above the constant space (64 KB by default) is answered with `rsp_err` = 1 and `rsp_data` = 0, and causes no memory fetch.
- R9: For an in-range address, `rsp_data` equals the backing-memory word at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A load is presented; held with its mask and addresses while `stall` is high |
| req_mask | input | NLANES | Active lanes of the load |
| req_addr | input | NLANES*WADDR_W | Word address per lane, lane 0 in the low bits |
| stall | output | 1 | Issuer must hold the load next cycle |
| rsp_valid | output | 1 | A word is returned this cycle |
| rsp_mask | output | NLANES | Lanes that receive `rsp_data` this cycle |
| rsp_data | output | DATA_W | Broadcast data word |
| rsp_err | output | 1 | Returned address was outside the constant space |
| mem_req_valid | output | 1 | Line fetch request |
| mem_req_ready | input | 1 | Backing memory accepts the fetch |
| mem_req_line | output | WADDR_W-log2(LINE_BYTES/4) | Line address to fetch |
| mem_rsp_valid | input | 1 | One fill word is present |
| mem_rsp_data | input | DATA_W | Fill word, lowest word of the line first |

## Verification
The bench builds the cache with 4 lanes, 16-byte lines, 4 lines and a 1 KB constant space (256 words) in a 10-bit word address. At this size it can sweep every word of the space with uniform loads. That sweep reaches every first-use miss and every eviction between lines that share an index. Several hundred mixed-mask, mixed-address loads then land on the same four indices and cross the space boundary. A small model of the tag state predicts the exact number of fetches for each load.

// File: rtl/const_cache_pkg.sv
// Shared types of the broadcast constant cache.
// Assumes: nothing beyond the 1800-2017 language.
package const_cache_pkg;

    // Line-fill sequencer states.
    typedef enum logic [1:0] {
        FILL_IDLE = 2'd0,
        FILL_REQ  = 2'd1,
        FILL_DATA = 2'd2
    } fill_state_e;

endpackage

// File: rtl/lane_arbiter.sv
// Picks the lowest-numbered pending lane as leader and marks every pending
// lane that shares its word address.
// Assumes: pend is already qualified with the issuer's valid.
module lane_arbiter #(
    parameter int NLANES = 8,
    parameter int ADDR_W = 18
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NLANES-1:0]          pend,
    input  logic [NLANES*ADDR_W-1:0]   lane_addr,
    output logic [NLANES-1:0]          leader_oh,
    output logic [NLANES-1:0]          match,
    output logic [ADDR_W-1:0]          leader_addr
);

    logic found;

    // Priority pick: first pending lane from lane 0 upward.
    always_comb begin
        leader_oh   = '0;
        leader_addr = '0;
        found       = 1'b0;
        for (int i = 0; i < NLANES; i++) begin
            if (pend[i] && !found) begin
                leader_oh[i] = 1'b1;
                leader_addr  = lane_addr[i*ADDR_W +: ADDR_W];
                found        = 1'b1;
            end
        end
    end

    // Per-lane comparator against the leader's address.
    for (genvar g = 0; g < NLANES; g++) begin : g_cmp
        assign match[g] = pend[g] && (lane_addr[g*ADDR_W +: ADDR_W] == leader_addr);
    end

    // R3: a single leader, and the leader is always among the served lanes.
    a_r3_single_leader: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(leader_oh) && ((leader_oh & ~match) == '0));

    // R3: any pending work yields exactly one leader.
    a_r3_leader_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend) |-> ($countones(leader_oh) == 1));

endmodule

// File: rtl/line_store.sv
// Direct-mapped tag, valid and data arrays with a combinational lookup port
// and a one-word-per-cycle fill port; commit sets tag and valid.
// Assumes: WPL and NLINES are powers of two; data is never reset.
module line_store #(
    parameter int NLINES = 128,
    parameter int WPL    = 16,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 5,
    localparam int IDX_W  = $clog2(NLINES),
    localparam int WOFF_W = $clog2(WPL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [WOFF_W-1:0] rd_woff,
    output logic              hit,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WOFF_W-1:0] wr_woff,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit_en,
    input  logic [IDX_W-1:0]  commit_idx,
    input  logic [TAG_W-1:0]  commit_tag
);

    logic [NLINES-1:0]  valid_q;
    logic [TAG_W-1:0]   tag_q  [NLINES];
    logic [DATA_W-1:0]  data_q [NLINES*WPL];

    // Lookup: tag compare and word read in the same cycle.
    assign hit     = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    assign rd_data = data_q[{rd_idx, rd_woff}];

    // Valid bits: cleared at reset, set when a fill completes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= '0;
        else if (commit_en)
            valid_q[commit_idx] <= 1'b1;
    end

    // Tag array: written on commit only.
    always_ff @(posedge clk) begin
        if (commit_en)
            tag_q[commit_idx] <= commit_tag;
    end

    // Data array: one fill word per cycle.
    always_ff @(posedge clk) begin
        if (wr_en)
            data_q[{wr_idx, wr_woff}] <= wr_data;
    end

    // R7: a committed line is resident on the following cycle.
    a_r7_commit_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |=> valid_q[$past(commit_idx)]);

    // R1: nothing is resident in the first cycle after reset.
    a_r1_empty_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (valid_q == '0));

endmodule

// File: rtl/fill_ctrl.sv
// Line-fill sequencer: issues one line request, holds it until accepted,
// then writes WPL response beats in ascending word order and commits.
// Assumes: the backing memory returns exactly WPL beats per request, in order.
module fill_ctrl
    import const_cache_pkg::*;
#(
    parameter int LINE_AW = 12,
    parameter int WPL     = 16,
    parameter int DATA_W  = 32,
    localparam int WOFF_W = $clog2(WPL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [LINE_AW-1:0] start_line,
    output logic               busy,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [LINE_AW-1:0] mem_req_line,
    input  logic               mem_rsp_valid,
    input  logic [DATA_W-1:0]  mem_rsp_data,
    output logic               wr_en,
    output logic [WOFF_W-1:0]  wr_woff,
    output logic [DATA_W-1:0]  wr_data,
    output logic               done,
    output logic [LINE_AW-1:0] line_q
);

    localparam logic [WOFF_W-1:0] LAST_BEAT = WOFF_W'(WPL - 1);

    fill_state_e       state_q;
    logic [WOFF_W-1:0] beat_q;

    // Sequencer: idle -> request -> collect beats -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FILL_IDLE;
            beat_q  <= '0;
            line_q  <= '0;
        end else begin
            case (state_q)
                FILL_IDLE: if (start) begin
                    line_q  <= start_line;
                    state_q <= FILL_REQ;
                end
                FILL_REQ: if (mem_req_ready) begin
                    beat_q  <= '0;
                    state_q <= FILL_DATA;
                end
                FILL_DATA: if (mem_rsp_valid) begin
                    beat_q <= beat_q + 1'b1;
                    if (beat_q == LAST_BEAT)
                        state_q <= FILL_IDLE;
                end
                default: state_q <= FILL_IDLE;
            endcase
        end
    end

    // Outputs decoded from the sequencer state.
    assign busy          = (state_q != FILL_IDLE);
    assign mem_req_valid = (state_q == FILL_REQ);
    assign mem_req_line  = line_q;
    assign wr_en         = (state_q == FILL_DATA) && mem_rsp_valid;
    assign wr_woff       = beat_q;
    assign wr_data       = mem_rsp_data;
    assign done          = wr_en && (beat_q == LAST_BEAT);

    // R6: an unaccepted request stays up with the same line address.
    a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_line)));

    // R6: a start is only taken while idle.
    a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);

endmodule

// File: rtl/const_bcast_cache.sv
// Read-only direct-mapped constant cache for a lane group. One word per
// cycle is broadcast to all pending lanes with the leader's address; other
// addresses are served on later cycles while stall is high. Misses fetch
// a whole line from the backing memory port.
// Assumes: the issuer holds req_valid, req_mask and req_addr unchanged while
// stall is high; all sizes are powers of two; lines are at least 2 words.
module const_bcast_cache #(
    parameter int NLANES      = 8,
    parameter int WADDR_W     = 18,
    parameter int DATA_W      = 32,
    parameter int SPACE_BYTES = 65536,
    parameter int CACHE_BYTES = 8192,
    parameter int LINE_BYTES  = 64,
    localparam int WPL     = LINE_BYTES / 4,
    localparam int NLINES  = CACHE_BYTES / LINE_BYTES,
    localparam int WOFF_W  = $clog2(WPL),
    localparam int IDX_W   = $clog2(NLINES),
    localparam int LINE_AW = WADDR_W - WOFF_W,
    localparam int TAG_W   = LINE_AW - IDX_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [NLANES-1:0]           req_mask,
    input  logic [NLANES*WADDR_W-1:0]   req_addr,
    output logic                        stall,
    output logic                        rsp_valid,
    output logic [NLANES-1:0]           rsp_mask,
    output logic [DATA_W-1:0]           rsp_data,
    output logic                        rsp_err,
    output logic                        mem_req_valid,
    input  logic                        mem_req_ready,
    output logic [WADDR_W-$clog2(LINE_BYTES/4)-1:0] mem_req_line,
    input  logic                        mem_rsp_valid,
    input  logic [DATA_W-1:0]           mem_rsp_data
);

    localparam logic [WADDR_W:0] SPACE_LIM = (WADDR_W+1)'(SPACE_BYTES / 4);

    logic [NLANES-1:0]  pend_q;
    logic               in_flight_q;
    logic [NLANES-1:0]  pend;
    logic [NLANES-1:0]  leader_oh;
    logic [NLANES-1:0]  match;
    logic [NLANES-1:0]  remaining;
    logic [WADDR_W-1:0] leader_addr;
    logic               leader_err;
    logic               hit;
    logic [DATA_W-1:0]  rd_data;
    logic               fill_busy;
    logic               start_fill;
    logic               serve;
    logic               wr_en;
    logic [WOFF_W-1:0]  wr_woff;
    logic [DATA_W-1:0]  wr_data;
    logic               fill_done;
    logic [LINE_AW-1:0] fill_line;

    // Lanes still to answer: fresh mask on the first cycle, saved set later.
    assign pend = !req_valid ? '0 : (in_flight_q ? pend_q : req_mask);

    lane_arbiter #(.NLANES(NLANES), .ADDR_W(WADDR_W)) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend        (pend),
        .lane_addr   (req_addr),
        .leader_oh   (leader_oh),
        .match       (match),
        .leader_addr (leader_addr)
    );

    // Range check and the decision between serving and fetching.
    assign leader_err = ({1'b0, leader_addr} >= SPACE_LIM);
    assign serve      = (|pend) && !fill_busy && (leader_err || hit);
    assign start_fill = (|pend) && !fill_busy && !leader_err && !hit;
    assign remaining  = pend & ~match;

    line_store #(.NLINES(NLINES), .WPL(WPL), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (leader_addr[WOFF_W +: IDX_W]),
        .rd_tag     (leader_addr[WADDR_W-1 -: TAG_W]),
        .rd_woff    (leader_addr[WOFF_W-1:0]),
        .hit        (hit),
        .rd_data    (rd_data),
        .wr_en      (wr_en),
        .wr_idx     (fill_line[IDX_W-1:0]),
        .wr_woff    (wr_woff),
        .wr_data    (wr_data),
        .commit_en  (fill_done),
        .commit_idx (fill_line[IDX_W-1:0]),
        .commit_tag (fill_line[LINE_AW-1 -: TAG_W])
    );

    fill_ctrl #(.LINE_AW(LINE_AW), .WPL(WPL), .DATA_W(DATA_W)) u_fill (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start_fill),
        .start_line    (leader_addr[WADDR_W-1:WOFF_W]),
        .busy          (fill_busy),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_line  (mem_req_line),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .wr_en         (wr_en),
        .wr_woff       (wr_woff),
        .wr_data       (wr_data),
        .done          (fill_done),
        .line_q        (fill_line)
    );

    // Response and stall toward the issuer.
    assign rsp_valid = serve;
    assign rsp_mask  = serve ? match : '0;
    assign rsp_err   = serve && leader_err;
    assign rsp_data  = (serve && !leader_err) ? rd_data : '0;
    assign stall     = (|pend) && !(serve && (remaining == '0));

    // Pending-lane bookkeeping across the cycles of one load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= '0;
            in_flight_q <= 1'b0;
        end else if (|pend) begin
            pend_q      <= serve ? remaining : pend;
            in_flight_q <= serve ? (|remaining) : 1'b1;
        end else begin
            pend_q      <= '0;
            in_flight_q <= 1'b0;
        end
    end

    // R5: only lanes of the presented mask are ever answered.
    a_r5_mask_in_request: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_mask & ~req_mask) == '0) && (rsp_mask != '0));

    // R6: no answer while a line fill is running.
    a_r6_quiet_during_fill: assert property (@(posedge clk) disable iff (!rst_n)
        fill_busy |-> !rsp_valid);

    // R8: an out-of-range answer carries zero data.
    a_r8_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && (rsp_data == '0)));

    // R4: a lane answered this cycle is not answered again in the same load.
    a_r4_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && stall) |=> ((rsp_mask & $past(rsp_mask)) == '0));

    // R1: the cycle after reset is quiet.
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (!mem_req_valid && !rsp_valid));

endmodule

// File: tb/tb_const_bcast_cache.sv
// Self-checking bench: small cache (4 lanes, 4 lines of 4 words, 256-word
// space), a backing-memory model with irregular ready and latency, and a
// reference tag model that predicts fetch counts.
module tb_const_bcast_cache;

    localparam int NL  = 4;
    localparam int WA  = 10;
    localparam int DW  = 32;
    localparam int SPW = 256;  // words in the constant space
    localparam int WPLN = 4;   // words per line
    localparam int NLN  = 4;   // lines
    localparam int LAW  = WA - 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [NL-1:0]     req_mask = '0;
    logic [NL*WA-1:0]  req_addr = '0;
    logic              stall, rsp_valid, rsp_err;
    logic [NL-1:0]     rsp_mask;
    logic [DW-1:0]     rsp_data;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b0;
    logic [LAW-1:0]    mem_req_line;
    logic              mem_rsp_valid = 1'b0;
    logic [DW-1:0]     mem_rsp_data = '0;

    int n_chk = 0, n_fail = 0, fills = 0, mcyc = 0;
    bit finished = 1'b0;

    const_bcast_cache #(
        .NLANES(NL), .WADDR_W(WA), .DATA_W(DW), .SPACE_BYTES(SPW*4),
        .CACHE_BYTES(NLN*WPLN*4), .LINE_BYTES(WPLN*4)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mask(req_mask),
        .req_addr(req_addr), .stall(stall), .rsp_valid(rsp_valid),
        .rsp_mask(rsp_mask), .rsp_data(rsp_data), .rsp_err(rsp_err),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_line(mem_req_line), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    always #5 clk = ~clk;

    function automatic logic [DW-1:0] bw(input int unsigned w);
        return DW'(w * 32'h0001_0003 + 32'h1234_5678);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Backing memory: irregular ready, 1-2 cycles of latency, 4 beats per line.
    int m_line = 0, m_beat = 0, m_delay = 0;
    bit m_busy = 1'b0;
    initial forever begin
        @(negedge clk);
        mcyc++;
        if (!rst_n) begin
            m_busy = 1'b0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
        end else if (m_busy) begin
            mem_req_ready = 1'b0;
            if (m_delay > 0) begin
                m_delay--; mem_rsp_valid = 1'b0;
            end else if (m_beat < WPLN) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = bw(m_line * WPLN + m_beat);
                m_beat++;
            end else begin
                mem_rsp_valid = 1'b0; m_busy = 1'b0;
            end
        end else begin
            mem_rsp_valid = 1'b0;
            mem_req_ready = (mcyc % 3) != 1;
            if (mem_req_valid && mem_req_ready) begin
                m_busy = 1'b1; m_line = int'(mem_req_line); m_beat = 0;
                m_delay = 1 + mcyc % 2; fills++;
            end
        end
    end

    // Reference direct-mapped tag state.
    bit ref_valid [NLN];
    int ref_line  [NLN];

    // Present one load, follow it until stall drops, check every cycle.
    task automatic run_req(input logic [NL-1:0] mask, input int w0, input int w1,
                           input int w2, input int w3);
        int w [NL];
        logic [NL-1:0] rem, same, tmp;
        int uniq = 0, expfill = 0, serves = 0, ncyc = 0, f0, lead, line, idx;
        bit done = 1'b0;
        w[0] = w0; w[1] = w1; w[2] = w2; w[3] = w3;
        // Expected distinct addresses and fetches in leader order.
        tmp = mask;
        while (tmp != '0) begin
            lead = 0;
            for (int i = NL-1; i >= 0; i--) if (tmp[i]) lead = i;
            for (int i = 0; i < NL; i++) if (tmp[i] && w[i] == w[lead]) tmp[i] = 1'b0;
            uniq++;
            if (w[lead] < SPW) begin
                line = w[lead] / WPLN; idx = line % NLN;
                if (!(ref_valid[idx] && ref_line[idx] == line)) begin
                    expfill++; ref_valid[idx] = 1'b1; ref_line[idx] = line;
                end
            end
        end
        f0 = fills;
        req_valid = 1'b1; req_mask = mask;
        for (int i = 0; i < NL; i++) req_addr[i*WA +: WA] = WA'(w[i]);
        rem = mask;
        while (!done) begin
            @(negedge clk);
            ncyc++;
            lead = 0; same = '0;
            for (int i = NL-1; i >= 0; i--) if (rem[i]) lead = i;
            for (int i = 0; i < NL; i++) if (rem[i] && w[i] == w[lead]) same[i] = 1'b1;
            if (mem_req_valid)
                chk(int'(mem_req_line) == w[lead] / WPLN, "R6 fetch line", mem_req_line, w[lead] / WPLN);
            if (rsp_valid) begin
                chk(rem != '0, "R5 response without pending lanes", rsp_mask, 0);
                chk(rsp_mask == same, "R3 served lanes", rsp_mask, same);
                if (w[lead] >= SPW)
                    chk(rsp_err && rsp_data == '0, "R8 out-of-range answer", {rsp_err, rsp_data}, 64'h1_0000_0000);
                else
                    chk(!rsp_err && rsp_data == bw(w[lead]), "R9 data", rsp_data, bw(w[lead]));
                rem = rem & ~rsp_mask;
                serves++;
            end
            chk(stall == (rem != '0), "R4 stall", stall, rem != '0);
            if (!stall) done = 1'b1;
            if (ncyc > 500) begin
                chk(1'b0, "R4 load never completes", ncyc, 0);
                done = 1'b1;
            end
        end
        @(posedge clk); #1;
        req_valid = 1'b0; req_mask = '0;
        chk(serves == uniq, "R4 serving cycles", serves, uniq);
        chk(fills - f0 == expfill, "R7 fetch count", fills - f0, expfill);
        if (mask != '0 && uniq == 1 && expfill == 0)
            chk(ncyc == 1, "R2 uniform hit in one cycle", ncyc, 1);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        for (int i = 0; i < NLN; i++) begin ref_valid[i] = 1'b0; ref_line[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!stall && !rsp_valid && !mem_req_valid, "R1 reset state",
            {stall, rsp_valid, mem_req_valid}, 0);
        @(posedge clk); #1;
        // R1/R6/R7/R9: uniform sweep of every word; first use of each line fetches.
        for (int wd = 0; wd < SPW; wd++) run_req(4'hF, wd, wd, wd, wd);
        // R2: the last lines of the sweep are resident; uniform hits, partial masks too.
        for (int wd = SPW - WPLN*NLN; wd < SPW; wd++) run_req(4'b1010 | 4'(wd & 1), wd, wd, wd, wd);
        // R5: empty mask gives nothing.
        run_req(4'h0, 3, 7, 11, 15);
        // R8: out-of-range uniform and mixed loads fetch nothing for those lanes.
        run_req(4'hF, SPW, SPW, SPW, SPW);
        run_req(4'hF, 1023, 5, 1023, SPW + 1);
        // R3/R4/R7: mixed masks and addresses, with duplicates and evictions.
        for (int p = 0; p < 400; p++) begin
            int k = p % 4;
            run_req(4'(p % 16), (p*13) % 300, (p*13 + 37*k) % 300,
                    (p*13 + 74*k) % 300, (p*13 + 111*k) % 300);
        end
        // R7: two lines sharing index 0 alternate and refetch each time.
        for (int r = 0; r < 4; r++) begin
            run_req(4'hF, 0, 0, 0, 0);
            run_req(4'hF, 16, 16, 16, 16);
        end
        summary();
    end

endmodule